// File: doc/BRIEF.md
# Immediate-Response Lockout Switch Debouncer

This block cleans up the level from a mechanical slide switch or push button. The raw pin first passes through a short chain of flip-flops clocked by the system clock. A two-state machine then tracks the cleaned level. The machine has one state for a low output and one for a high output.

The output follows a new input level on the first clock edge after that level leaves the synchronizer. It does not wait for the input to stay stable. After every output change, a lockout counter starts. The machine ignores the input until the counter has run through its whole range and returned to zero. This gives an output with no added settling delay and no chatter, as long as the lockout covers the contact bounce.

The counter keeps stepping for as long as it is nonzero. It does not depend on a separate start flag. A glitch therefore cannot leave the counter stranded at a nonzero value, and it cannot leave the output frozen. With the default width of 20 bits, the lockout is 1,048,576 cycles, about 21 ms at 50 MHz. That is well above the roughly 2 ms of bounce typical of such contacts.

Top module: `lockout_debouncer`

## Requirements
- R1: While `rst_ni` is low and `raw_i` has been steady for at least SYNC_STAGES+1 clock edges, `level_o` equals `raw_i`. The lockout counter is cleared, so the first qualifying change after release is accepted at once.
- R2: When idle (no lockout running), `level_o` low, and `raw_i` rising, `level_o` goes high on exactly the (SYNC_STAGES+1)-th rising clock edge after `raw_i` changed.
- R3: When idle, `level_o` high, and `raw_i` falling, `level_o` goes low on exactly the (SYNC_STAGES+1)-th rising clock edge after `raw_i` changed.
- R4: After any change of `level_o`, the output holds its new value for at least 2^CNT_W clock cycles, whatever `raw_i` does during that time.
- R5: At the end of a lockout, the synchronized input may differ from `level_o`. In that case `level_o` changes on exactly the 2^CNT_W-th edge after the previous change.
- R6: A single-cycle pulse on `raw_i` against an idle level flips `level_o` for exactly 2^CNT_W cycles. The output then returns to the steady input level and stays there, so the output never becomes stuck.
- R7: A burst of one-cycle toggles on `raw_i` that ends at the opposite level gives exactly one transition of `level_o`, in either direction.
- R8: While idle, if `raw_i` matches `level_o`, the output does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk_i` |
| raw_i | input | 1 | Raw bouncing switch level, asynchronous to `clk_i` |
| level_o | output | 1 | Debounced, registered switch level |

## Verification
The checker watches the synchronized level, not the raw pin. It therefore assumes the synchronizer output is a clean logic value on every edge. It also assumes reset is held long enough to flush the synchronizer chain before the first checked edge. The bench meets both assumptions in the following ways:
- It changes `raw_i` only at falling clock edges.
- It holds reset for several cycles with a steady input.
- It produces its 20 ns glitches as whole-cycle pulses, so every glitch is sampled exactly once.

A lockout width of 6 bits keeps each lockout window to 64 cycles, so every window can be observed in full.

// File: rtl/lockout_pkg.sv
package lockout_pkg;

  // One state per debounced output level.
  typedef enum logic {
    ST_LOW  = 1'b0,
    ST_HIGH = 1'b1
  } lvl_state_e;

endpackage

// File: rtl/lockout_sync.sv
module lockout_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Shift the raw level one flop further down the chain on each edge.
  always_comb begin
    chain_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  // Synchronizer flops carry no reset; reset depth is covered by holding
  // reset for more than STAGES cycles.
  always_ff @(posedge clk_i) begin
    chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/lockout_timer.sv
module lockout_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // The counter runs whenever it is nonzero, so it always comes back to zero.
  assign busy_o = |cnt_q;
  assign cnt_en = start_i | busy_o;

  always_comb begin
    if (start_i) begin
      cnt_d = CntOne;
    end else begin
      cnt_d = cnt_q + CntOne;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/lockout_fsm.sv
module lockout_fsm
  import lockout_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  input  logic       busy_i,
  output lvl_state_e state_o,
  output logic       start_o
);

  lvl_state_e state_q;
  lvl_state_e state_d;
  lvl_state_e seed_state;

  assign seed_state = sync_i ? ST_HIGH : ST_LOW;

  // Next-state logic: accept an opposite level only when no lockout is running.
  always_comb begin
    state_d = state_q;
    start_o = 1'b0;
    unique case (state_q)
      ST_LOW: begin
        if (!busy_i && sync_i) begin
          state_d = ST_HIGH;
          start_o = 1'b1;
        end
      end
      ST_HIGH: begin
        if (!busy_i && !sync_i) begin
          state_d = ST_LOW;
          start_o = 1'b1;
        end
      end
      default: begin
        state_d = seed_state;
      end
    endcase
  end

  // While reset is held, the state is loaded from the synchronized input, so
  // leaving reset enters the state that matches the switch.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= seed_state;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/lockout_debouncer.sv
module lockout_debouncer
  import lockout_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o
);

  logic             sync_lvl;
  logic             lock_busy;
  logic             lock_start;
  logic [CNT_W-1:0] lock_cnt;
  lvl_state_e       lvl_state;

  lockout_sync #(
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk_i (clk_i),
    .d_i   (raw_i),
    .q_o   (sync_lvl)
  );

  lockout_fsm fsm_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_lvl),
    .busy_i  (lock_busy),
    .state_o (lvl_state),
    .start_o (lock_start)
  );

  lockout_timer #(
    .CNT_W (CNT_W)
  ) timer_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (lock_start),
    .busy_o  (lock_busy),
    .count_o (lock_cnt)
  );

  assign level_o = (lvl_state == ST_HIGH);

endmodule

// File: rtl/lockout_debouncer_chk.sv
module lockout_debouncer_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             level_i
);

  // R4
  no_change_in_lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i != $past(level_i)) |-> ($past(cnt_i) == '0));

  // R4
  change_starts_lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i != $past(level_i)) |-> (cnt_i == CNT_W'(1)));

  // R6
  counter_never_parks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |=> (cnt_i != $past(cnt_i)));

  // R2
  idle_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0 && sync_i != level_i) |=> (level_i == $past(sync_i)));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0 && sync_i == level_i) |=> $stable(level_i));

  // R4
  lockout_only_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_i) == '0 && cnt_i != '0) |-> (level_i != $past(level_i)));

endmodule

bind lockout_debouncer lockout_debouncer_chk #(
  .CNT_W (CNT_W)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sync_i  (sync_lvl),
  .cnt_i   (lock_cnt),
  .level_i (level_o)
);

// File: tb/lockout_debouncer_tb_top.sv
`timescale 1ns/1ps
module lockout_debouncer_tb_top;

  localparam int CNT_W  = 6;
  localparam int STAGES = 2;
  localparam int LOCK   = 1 << CNT_W;

  logic clk;
  logic rst_n;
  logic raw;
  logic level;

  int checks;
  int fails;
  int toggles;
  logic prev_level;

  lockout_debouncer #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (STAGES)
  ) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .raw_i   (raw),
    .level_o (level)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Count output transitions just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (level !== prev_level) toggles++;
    prev_level = level;
  end

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle(input logic lvl);
    raw = lvl;
    step(2 * LOCK + STAGES + 4);
  endtask

  task automatic test_reset();
    raw   = 1'b1;
    rst_n = 1'b0;
    step(5);
    check(level, 1'b1, "R1", "reset with input high");
    raw = 1'b0;
    step(STAGES + 2);
    check(level, 1'b0, "R1", "reset follows input low");
    rst_n = 1'b1;
    step(2);
    check(level, 1'b0, "R1", "level after release");
  endtask

  task automatic test_idle_hold();
    settle(1'b0);
    toggles = 0;
    step(50);
    check_int(toggles, 0, "R8", "idle low transitions");
    check(level, 1'b0, "R8", "idle low level");
  endtask

  task automatic test_rise();
    settle(1'b0);
    raw = 1'b1;
    step(STAGES);
    check(level, 1'b0, "R2", "level before sync latency");
    step(1);
    check(level, 1'b1, "R2", "level after sync latency");
  endtask

  task automatic test_fall();
    settle(1'b1);
    raw = 1'b0;
    step(STAGES);
    check(level, 1'b1, "R3", "level before sync latency");
    step(1);
    check(level, 1'b0, "R3", "level after sync latency");
  endtask

  task automatic test_glitch(input logic idle);
    settle(idle);
    toggles = 0;
    raw = ~idle;
    step(1);
    raw = idle;
    step(STAGES);
    check(level, ~idle, "R6", "glitch accepted");
    step(LOCK - 1);
    check(level, ~idle, "R4", "held through lockout");
    step(1);
    check(level, idle, "R6", "returned after lockout");
    step(LOCK + 10);
    check(level, idle, "R6", "not stuck after glitch");
    check_int(toggles, 2, "R6", "glitch transitions");
  endtask

  task automatic test_burst(input logic idle);
    logic [9:0] pat;
    settle(idle);
    toggles = 0;
    pat = 10'b1011010011;
    for (int i = 0; i < 10; i++) begin
      raw = idle ^ pat[i];
      step(1);
    end
    raw = ~idle;
    step(3 * LOCK);
    check_int(toggles, 1, "R7", "burst transitions");
    check(level, ~idle, "R7", "final level after burst");
  endtask

  task automatic test_retrigger();
    settle(1'b0);
    raw = 1'b1;
    step(STAGES + 1);
    check(level, 1'b1, "R5", "first change");
    raw = 1'b0;
    step(LOCK - 1);
    check(level, 1'b1, "R4", "input low ignored in lockout");
    step(1);
    check(level, 1'b0, "R5", "change at lockout end");
  endtask

  initial begin
    checks     = 0;
    fails      = 0;
    toggles    = 0;
    prev_level = 1'b0;
    raw        = 1'b0;
    rst_n      = 1'b0;
    step(1);
    test_reset();
    test_idle_hold();
    test_rise();
    test_fall();
    test_glitch(1'b0);
    test_glitch(1'b1);
    test_burst(1'b0);
    test_burst(1'b1);
    test_retrigger();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #3_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule